// File: doc/BRIEF.md
# Single-Vector Interrupt Collector

This block gathers four interrupt sources for a small 8-bit controller core. The sources are an external pin edge, a timer overflow pulse, a change on the upper nibble of an input port, and a pulse that marks the end of a nonvolatile write. Each source has a sticky flag and an enable bit. One global enable gates the request to the core. All of this state sits in a single 10-bit control word that software reads and writes.

Every source leads to the same fixed vector, so the handler has to poll the flags to find the cause. Hardware never clears a flag. Software clears a flag by writing 0 to its bit.

When the core accepts the interrupt, it pulses an entry input and the global enable drops. A return pulse sets the global enable again. A separate wake output tells a sleep controller that an enabled source is pending, whatever the state of the global enable.

Top module: `irq_hub`

## Requirements
- R1: After reset the control word reads 0x200. That is all flags and enables 0, global enable 0, and edge select 1. Control word layout: bits 3..0 are the flags, in the order external, timer, port-change, write-done. Bits 7..4 are the enables in the same order. Bit 8 is the global enable. Bit 9 is the edge select, where 1 means rising.
- R2: Flag bit 0 sets on the active edge of `ext_pin`, which is rising when bit 9 is 1 and falling when bit 9 is 0. The flag appears three clock edges after the pin changes. An edge of the other polarity does not set it.
- R3: A one-cycle `tmr_ovf` pulse sets flag bit 1 at the next clock edge.
- R4: Flag bit 2 sets when `port_in[7:4]` differs from the latched copy. A change that is confined to `port_in[3:0]` does not set it.
- R5: A `port_rd` pulse loads `port_in[7:4]` into the latched copy. After that, the same port value no longer sets flag bit 2.
- R6: A `nvm_done` pulse sets flag bit 3 at the next clock edge.
- R7: A flag sets on its event even while its enable bit is 0.
- R8: `irq_req` is high exactly when bit 8 is 1 and at least one flag has its enable set.
- R9: `wake_req` is high whenever at least one flag has its enable set, regardless of bit 8.
- R10: `vec_addr` always presents the shared vector 0x0004.
- R11: A `vec_take` pulse clears bit 8 at the next edge and leaves the flags unchanged.
- R12: An `irq_ret` pulse without `vec_take` sets bit 8 at the next edge.
- R13: A write to the control word loads all ten bits. If a source event lands in the same cycle as the write, the event wins and the flag ends up set. Apart from such a write, a flag holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_in | input | 8 | Input port value |
| port_rd | input | 1 | Port read strobe, refreshes the latched nibble |
| nvm_done | input | 1 | Nonvolatile write complete pulse |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Control word write data |
| ctl_rdata | output | 10 | Control word read data |
| vec_take | input | 1 | Core interrupt entry pulse |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake request to the sleep controller |
| vec_addr | output | 13 | Shared interrupt vector address |

## Verification
The bench writes the control word in the same cycle as a timer pulse. A design that let the write win would drop an event. It clears the global enable while an enabled flag stays set. The request must fall while the wake output stays high, so a design that gated wake with the global enable would fail here. The bench counts clock edges through the synchronizer after an external pin change, and it flips the pin with the opposite polarity selected. A missing synchronizer stage or an inverted edge select would be caught by this. It also changes only the low port nibble, and it reads the port before clearing the change flag. A design that compared all eight bits, or that never refreshed its copy, would raise a change flag that should stay clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 4;
  localparam int CTL_W    = 10;
  localparam int FLG_LSB  = 0;
  localparam int EN_LSB   = 4;
  localparam int GIE_BIT  = 8;
  localparam int EDGE_BIT = 9;

  typedef enum int {
    SRC_EXT = 0,
    SRC_TMR = 1,
    SRC_CHG = 2,
    SRC_NVM = 3
  } src_e;

  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << EDGE_BIT;

  // any source whose flag and enable are both set
  function automatic logic armed_any(input logic [NSRC-1:0] flg,
                                     input logic [NSRC-1:0] en);
    return |(flg & en);
  endfunction

  function automatic logic req_of(input logic [NSRC-1:0] flg,
                                  input logic [NSRC-1:0] en,
                                  input logic gie);
    return gie & armed_any(flg, en);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              lvl;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign lvl = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  assign hit = rise_sel ? (lvl & ~prev) : (~lvl & prev);
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
  parameter int PORT_W = 8,
  parameter int LO     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  output logic              mism
);
  localparam int HW = PORT_W - LO;
  logic [HW-1:0] snap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       snap <= '0;
    else if (port_rd) snap <= port_in[PORT_W-1:LO];

  assign mism = |(port_in[PORT_W-1:LO] ^ snap);
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  evt,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             take,
  input  logic             ret,
  output logic [CTL_W-1:0] ctl_q
);
  logic [NSRC-1:0] flg, en;
  logic            gie, edge_r;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      flg[s] <= 1'b0;
        else if (evt[s]) flg[s] <= 1'b1;
        else if (we)     flg[s] <= wdata[FLG_LSB+s];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)  en[s] <= 1'b0;
        else if (we) en[s] <= wdata[EN_LSB+s];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    gie <= 1'b0;
    else if (take) gie <= 1'b0;
    else if (ret)  gie <= 1'b1;
    else if (we)   gie <= wdata[GIE_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  edge_r <= CTL_RESET[EDGE_BIT];
    else if (we) edge_r <= wdata[EDGE_BIT];

  assign ctl_q = {edge_r, gie, en, flg};
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
#(
  parameter int                 PORT_W      = 8,
  parameter int                 CHG_LO      = 4,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 ADDR_W      = 13,
  parameter logic [ADDR_W-1:0]  VEC_ADDR    = 'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  input  logic              nvm_done,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              vec_take,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic              wake_req,
  output logic [ADDR_W-1:0] vec_addr
);
  logic            ext_hit;
  logic            chg_hit;
  logic [NSRC-1:0] src_evt;
  logic [CTL_W-1:0] ctl_q;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .rise_sel(ctl_q[EDGE_BIT]), .hit(ext_hit)
  );

  irq_chg_det #(.PORT_W(PORT_W), .LO(CHG_LO)) u_chg (
    .clk(clk), .rst_n(rst_n), .port_in(port_in),
    .port_rd(port_rd), .mism(chg_hit)
  );

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_EXT] = ext_hit;
    src_evt[SRC_TMR] = tmr_ovf;
    src_evt[SRC_CHG] = chg_hit;
    src_evt[SRC_NVM] = nvm_done;
  end

  irq_flags u_flg (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .we(ctl_we),
    .wdata(ctl_wdata), .take(vec_take), .ret(irq_ret), .ctl_q(ctl_q)
  );

  assign ctl_rdata = ctl_q;
  assign irq_req   = req_of(ctl_q[FLG_LSB +: NSRC], ctl_q[EN_LSB +: NSRC],
                            ctl_q[GIE_BIT]);
  assign wake_req  = armed_any(ctl_q[FLG_LSB +: NSRC], ctl_q[EN_LSB +: NSRC]);
  assign vec_addr  = VEC_ADDR;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_ovf,
  input logic             nvm_done,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             vec_take,
  input logic             irq_ret,
  input logic             irq_req,
  input logic             wake_req,
  input logic             ext_hit,
  input logic             chg_hit
);
  assert_ext_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> ctl_rdata[FLG_LSB+SRC_EXT]);
  assert_tmr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctl_rdata[FLG_LSB+SRC_TMR]);
  assert_chg_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_hit |=> ctl_rdata[FLG_LSB+SRC_CHG]);
  assert_nvm_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_done |=> ctl_rdata[FLG_LSB+SRC_NVM]);
  assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ctl_rdata[GIE_BIT] && wake_req));
  assert_wake_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> |(ctl_rdata[FLG_LSB +: NSRC] & ctl_rdata[EN_LSB +: NSRC]));
  assert_take_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> !ctl_rdata[GIE_BIT]);
  assert_ret_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !vec_take) |=> ctl_rdata[GIE_BIT]);
  assert_flag_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[FLG_LSB+SRC_TMR] && !ctl_we) |=> ctl_rdata[FLG_LSB+SRC_TMR]);
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .nvm_done(nvm_done),
  .ctl_we(ctl_we), .ctl_rdata(ctl_rdata), .vec_take(vec_take),
  .irq_ret(irq_ret), .irq_req(irq_req), .wake_req(wake_req),
  .ext_hit(ext_hit), .chg_hit(chg_hit)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b0, tmr_ovf = 1'b0, port_rd = 1'b0, nvm_done = 1'b0;
  logic [7:0]  port_in = 8'h00;
  logic        ctl_we = 1'b0, vec_take = 1'b0, irq_ret = 1'b0;
  logic [9:0]  ctl_wdata = '0;
  logic [9:0]  ctl_rdata;
  logic        irq_req, wake_req;
  logic [12:0] vec_addr;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_in(port_in), .port_rd(port_rd), .nvm_done(nvm_done),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .vec_take(vec_take), .irq_ret(irq_ret), .irq_req(irq_req),
    .wake_req(wake_req), .vec_addr(vec_addr)
  );

  typedef struct packed {
    logic       tmr;
    logic       nvm;
    logic [7:0] port;
    logic       rd;
    logic       we;
    logic [9:0] wd;
    logic       take;
    logic       ret;
    logic [9:0] ectl;
    logic       eirq;
    logic       ewake;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,8'h00,1'b0,1'b0,10'h000,1'b0,1'b0,10'h200,1'b0,1'b0}, // idle
    '{1'b1,1'b0,8'h00,1'b0,1'b0,10'h000,1'b0,1'b0,10'h202,1'b0,1'b0}, // R3 R7
    '{1'b0,1'b0,8'h00,1'b0,1'b1,10'h320,1'b0,1'b0,10'h320,1'b0,1'b0}, // R13 clear
    '{1'b1,1'b0,8'h00,1'b0,1'b0,10'h000,1'b0,1'b0,10'h322,1'b1,1'b1}, // R8
    '{1'b0,1'b0,8'h00,1'b0,1'b0,10'h000,1'b1,1'b0,10'h222,1'b0,1'b1}, // R11 R9
    '{1'b0,1'b0,8'h00,1'b0,1'b0,10'h000,1'b0,1'b1,10'h322,1'b1,1'b1}, // R12
    '{1'b1,1'b0,8'h00,1'b0,1'b1,10'h320,1'b0,1'b0,10'h322,1'b1,1'b1}, // R13 event wins
    '{1'b0,1'b0,8'h00,1'b0,1'b1,10'h320,1'b0,1'b0,10'h320,1'b0,1'b0}, // R13
    '{1'b0,1'b1,8'h00,1'b0,1'b0,10'h000,1'b0,1'b0,10'h328,1'b0,1'b0}, // R6 R7
    '{1'b0,1'b0,8'h0F,1'b0,1'b0,10'h000,1'b0,1'b0,10'h328,1'b0,1'b0}, // R4 low nibble
    '{1'b0,1'b0,8'h1F,1'b0,1'b0,10'h000,1'b0,1'b0,10'h32C,1'b0,1'b0}, // R4
    '{1'b0,1'b0,8'h1F,1'b1,1'b0,10'h000,1'b0,1'b0,10'h32C,1'b0,1'b0}, // R5 read
    '{1'b0,1'b0,8'h1F,1'b0,1'b1,10'h300,1'b0,1'b0,10'h300,1'b0,1'b0}, // R5
    '{1'b0,1'b0,8'h1F,1'b0,1'b0,10'h000,1'b0,1'b0,10'h300,1'b0,1'b0}, // R5 stays
    '{1'b0,1'b0,8'h1F,1'b0,1'b1,10'h3F0,1'b0,1'b0,10'h3F0,1'b0,1'b0}, // R8
    '{1'b0,1'b0,8'h9F,1'b0,1'b0,10'h000,1'b0,1'b0,10'h3F4,1'b1,1'b1}, // R4 R8
    '{1'b0,1'b0,8'h9F,1'b0,1'b1,10'h2F0,1'b0,1'b0,10'h2F4,1'b0,1'b1}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [9:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    edge_wait();
    @(negedge clk); ctl_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset ctl", 32'(ctl_rdata), 32'h200);
    chk("R1 reset irq", 32'(irq_req), 32'h0);
    chk("R10 vector", 32'(vec_addr), 32'h0004);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tmr_ovf = TBL[i].tmr;   nvm_done = TBL[i].nvm;
      port_in = TBL[i].port;  port_rd  = TBL[i].rd;
      ctl_we  = TBL[i].we;    ctl_wdata = TBL[i].wd;
      vec_take = TBL[i].take; irq_ret  = TBL[i].ret;
      edge_wait();
      chk($sformatf("row%0d ctl", i), 32'(ctl_rdata), 32'(TBL[i].ectl));
      chk($sformatf("row%0d irq R8", i), 32'(irq_req), 32'(TBL[i].eirq));
      chk($sformatf("row%0d wake R9", i), 32'(wake_req), 32'(TBL[i].ewake));
    end
    @(negedge clk);
    tmr_ovf = 0; nvm_done = 0; port_rd = 0; ctl_we = 0; vec_take = 0; irq_ret = 0;

    // refresh port copy, then clear flags
    @(negedge clk); port_rd = 1'b1;
    edge_wait();
    @(negedge clk); port_rd = 1'b0;
    wr(10'h3F0);
    chk("R5 cleared", 32'(ctl_rdata), 32'h3F0);

    // R2 rising edge latency: flag after third edge
    ext_pin = 1'b1;
    edge_wait();
    chk("R2 edge1", 32'(ctl_rdata), 32'h3F0);
    edge_wait();
    chk("R2 edge2", 32'(ctl_rdata), 32'h3F0);
    edge_wait();
    chk("R2 rise flag", 32'(ctl_rdata), 32'h3F1);
    chk("R2 rise irq R8", 32'(irq_req), 32'h1);

    // R2 falling mode
    wr(10'h1F0);
    chk("R2 fall mode set", 32'(ctl_rdata), 32'h1F0);
    ext_pin = 1'b0;
    repeat (3) edge_wait();
    chk("R2 fall flag", 32'(ctl_rdata), 32'h1F1);
    wr(10'h1F0);
    ext_pin = 1'b1;
    repeat (4) edge_wait();
    chk("R2 rise ignored in fall mode", 32'(ctl_rdata), 32'h1F0);
    chk("R10 vector hold", 32'(vec_addr), 32'h0004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule